// File: doc/BRIEF.md
# Ping-Pong Macroblock Stage Buffer

This block sits between two macroblock pipeline stages. Its sample memory holds two regions, each large enough for one macroblock. The upstream stage fills one region while the downstream stage reads the macroblock finished before it from the other region. When both stages have finished, the two regions change roles. Only a bank-select bit flips, so no data is copied and no cycles are spent moving samples.

Each side addresses words local to one macroblock, and the buffer adds the region bit itself. A parameter picks the word format. In packed mode a word holds four samples that form one column of a 4x4 block. In unpacked mode a word holds a single sample. The small per-macroblock control word does not go into the RAM. It is held in a pair of registers that change roles on the same event as the regions, so the consumer always sees the control word that belongs to the samples it reads.

Top module: `mbpp_stage_ram`

## Requirements
- R1: While reset is held and after its release, `cons_valid` is 0, `prod_ready` is 1, `swap` is 0 and `rd_ctrl` is 0.
- R2: Regions are exchanged only when the producer is done and the consumer region is free. The producer is done if it pulsed `wr_done` this cycle or has a finish pending. The consumer region is free if `cons_valid` is 0 or `rd_done` is pulsed this cycle. `swap` is high for exactly the one cycle after the exchange edge, and in that cycle `cons_valid` is 1 and `prod_ready` is 1.
- R3: After a `wr_done` that cannot swap, `prod_ready` is 0 from the next cycle until the exchange. During that time writes and further `wr_done` pulses (with their control word) are ignored, and the pending macroblock reaches the consumer unchanged.
- R4: After an exchange, reading local address A returns the word the producer wrote at A before its `wr_done`. This holds while the producer writes the other region at the same time.
- R5: `rd_data` shows the word addressed by `rd_addr` in the cycle after `rd_en` is high.
- R6: A `rd_done` with no producer finish pending clears `cons_valid` in the next cycle and causes no `swap`.
- R7: The control word present on `wr_ctrl` with an accepted `wr_done` appears on `rd_ctrl` in the `swap` cycle. It stays stable until the next exchange.
- R8: In packed mode (`PACKED`=1) a word is 4×`SAMPLE_W` bits. Bits [k*SAMPLE_W +: SAMPLE_W] hold row k of a 4x4 block column, with row 0 in the least significant lane. One macroblock spans `MB_SAMPLES`/4 words, addressed 0 upward.
- R9: `wr_done` and `rd_done` in the same cycle while `cons_valid` is 1 produce an exchange on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Producer write strobe |
| wr_addr | input | ADDR_W | Producer word address within the macroblock |
| wr_data | input | WORD_W | Producer word (one sample, or a four-sample column) |
| wr_done | input | 1 | Producer finished its macroblock (one-cycle pulse) |
| wr_ctrl | input | CTRL_W | Control word for the finished macroblock, taken with wr_done |
| prod_ready | output | 1 | Producer region accepts writes |
| rd_en | input | 1 | Consumer read strobe |
| rd_addr | input | ADDR_W | Consumer word address within the macroblock |
| rd_data | output | WORD_W | Read word, one cycle after rd_en |
| rd_done | input | 1 | Consumer finished its macroblock (one-cycle pulse) |
| rd_ctrl | output | CTRL_W | Control word belonging to the consumer region |
| cons_valid | output | 1 | Consumer region holds an unconsumed macroblock |
| swap | output | 1 | One-cycle pulse after the regions exchanged roles |

## Verification
The assertions assume that `wr_done` and `rd_done` are single-cycle pulses and that `rd_done` is raised only while `cons_valid` is high. The stimulus respects this. Every done pulse lasts one cycle, `rd_done` is issued only after a macroblock has been handed over, and addresses stay below the macroblock word count. Writes and done pulses sent while the producer is blocked are the one deliberate excursion. They exercise the rule that such inputs are dropped.

// File: rtl/mbpp_pkg.sv
package mbpp_pkg;
  localparam int unsigned COL_ROWS = 4;

  function automatic int unsigned word_bits(int unsigned sample_w, bit packed_mode);
    return packed_mode ? sample_w * COL_ROWS : sample_w;
  endfunction

  function automatic int unsigned mb_words(int unsigned samples, bit packed_mode);
    return packed_mode ? samples / COL_ROWS : samples;
  endfunction
endpackage

// File: rtl/mbpp_swap_ctl.sv
module mbpp_swap_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_done,
  input  logic rd_done,
  output logic sel,
  output logic prod_ready,
  output logic cons_valid,
  output logic swap,
  output logic done_take
);
  logic sel_q, sel_d;
  logic pend_q, pend_d;
  logic full_q, full_d;
  logic swap_q, swap_d;
  logic prod_fin, cons_free;

  always_comb begin
    prod_fin  = pend_q | wr_done;
    cons_free = ~full_q | rd_done;
    swap_d    = prod_fin & cons_free;
    sel_d     = sel_q;
    pend_d    = pend_q;
    full_d    = full_q;
    if (swap_d) begin
      sel_d  = ~sel_q;
      pend_d = 1'b0;
      full_d = 1'b1;
    end else begin
      pend_d = prod_fin;
      full_d = full_q & ~rd_done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      pend_q <= 1'b0;
      full_q <= 1'b0;
      swap_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      pend_q <= pend_d;
      full_q <= full_d;
      swap_q <= swap_d;
    end
  end

  assign sel        = sel_q;
  assign prod_ready = ~pend_q;
  assign cons_valid = full_q;
  assign swap       = swap_q;
  assign done_take  = wr_done & ~pend_q;
endmodule

// File: rtl/mbpp_region_ram.sv
module mbpp_region_ram #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_bank,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 2 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_bank, wr_addr}] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[{rd_bank, rd_addr}];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/mbpp_ctrl_bank.sv
module mbpp_ctrl_bank #(
  parameter int unsigned CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              take,
  input  logic [CTRL_W-1:0] wr_ctrl,
  output logic [CTRL_W-1:0] rd_ctrl
);
  logic [CTRL_W-1:0] ctrl_q [2];

  for (genvar b = 0; b < 2; b++) begin : g_set
    logic load;
    assign load = take & (sel != b[0]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ctrl_q[b] <= '0;
      else if (load) ctrl_q[b] <= wr_ctrl;
    end
  end

  assign rd_ctrl = ctrl_q[sel];
endmodule

// File: rtl/mbpp_stage_ram.sv
module mbpp_stage_ram #(
  parameter int unsigned SAMPLE_W   = 8,
  parameter int unsigned MB_SAMPLES = 384,
  parameter bit          PACKED     = 1'b1,
  parameter int unsigned CTRL_W     = 16,
  localparam int unsigned WORD_W    = mbpp_pkg::word_bits(SAMPLE_W, PACKED),
  localparam int unsigned MB_WORDS  = mbpp_pkg::mb_words(MB_SAMPLES, PACKED),
  localparam int unsigned ADDR_W    = (MB_WORDS > 1) ? $clog2(MB_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_done,
  input  logic [CTRL_W-1:0] wr_ctrl,
  output logic              prod_ready,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic              rd_done,
  output logic [CTRL_W-1:0] rd_ctrl,
  output logic              cons_valid,
  output logic              swap
);
  logic sel;
  logic done_take;
  logic ram_we;

  mbpp_swap_ctl u_swap (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_done    (wr_done),
    .rd_done    (rd_done),
    .sel        (sel),
    .prod_ready (prod_ready),
    .cons_valid (cons_valid),
    .swap       (swap),
    .done_take  (done_take)
  );

  assign ram_we = wr_en & prod_ready;

  mbpp_region_ram #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ram (
    .clk     (clk),
    .wr_en   (ram_we),
    .wr_bank (~sel),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_bank (sel),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  mbpp_ctrl_bank #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .take    (done_take),
    .wr_ctrl (wr_ctrl),
    .rd_ctrl (rd_ctrl)
  );
endmodule

// File: rtl/mbpp_stage_ram_chk.sv
module mbpp_stage_ram_chk #(
  parameter int unsigned CTRL_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_done,
  input logic              rd_done,
  input logic              prod_ready,
  input logic              cons_valid,
  input logic              swap,
  input logic [CTRL_W-1:0] rd_ctrl
);
  // R2: an exchange needs a finished producer and a free consumer region
  p_swap_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    swap |-> $past(wr_done || !prod_ready) && $past(rd_done || !cons_valid));

  // R2: right after an exchange both sides are open
  p_swap_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
    swap |-> cons_valid && prod_ready);

  // R2: the consumer region only becomes valid through an exchange
  p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cons_valid) |-> swap);

  // R3: the producer is blocked only by its own finish
  p_block_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prod_ready) |-> $past(wr_done));

  // R6: the consumer region is released only by the consumer
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cons_valid) |-> $past(rd_done));

  // R7: control seen by the consumer moves only with an exchange
  p_ctrl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !swap |-> $stable(rd_ctrl));
endmodule

bind mbpp_stage_ram mbpp_stage_ram_chk #(.CTRL_W(CTRL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_done    (wr_done),
  .rd_done    (rd_done),
  .prod_ready (prod_ready),
  .cons_valid (cons_valid),
  .swap       (swap),
  .rd_ctrl    (rd_ctrl)
);

// File: tb/mbpp_stage_ram_bench.sv
module mbpp_stage_ram_bench;
  localparam int SW     = 8;
  localparam int NS     = 384;
  localparam int CW     = 16;
  localparam int WW     = 4 * SW;
  localparam int NW     = NS / 4;
  localparam int AW     = $clog2(NW);
  localparam real HALF  = 2.5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, wr_done, rd_en, rd_done;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [WW-1:0] wr_data, rd_data;
  logic [CW-1:0] wr_ctrl, rd_ctrl;
  logic          prod_ready, cons_valid, swap;

  int n_vec  = 0;
  int n_fail = 0;
  logic [WW-1:0] exp_q [$];
  logic rd_seen = 1'b0;

  always #HALF clk = ~clk;

  mbpp_stage_ram u_mbpp_stage_ram (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_done(wr_done), .wr_ctrl(wr_ctrl), .prod_ready(prod_ready),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_done(rd_done), .rd_ctrl(rd_ctrl), .cons_valid(cons_valid), .swap(swap)
  );

  // R8: lane k holds row k, row 0 least significant
  function automatic logic [WW-1:0] word_of(int m, int a);
    logic [WW-1:0] w;
    for (int k = 0; k < 4; k++) w[k*SW +: SW] = 8'((m * 97 + a * 4 + k) & 255);
    return w;
  endfunction

  function automatic logic [CW-1:0] ctrl_of(int m);
    return 16'(16'h1000 + m * 16'h0111);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      logic [WW-1:0] e;
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected read", rd_data, 0);
      end else begin
        e = exp_q.pop_front();
        check(rd_data === e, "R4/R5 read data", rd_data, e);
      end
    end
  end

  task automatic idle();
    wr_en = 0; wr_done = 0; rd_en = 0; rd_done = 0;
  endtask

  // write macroblock wm (if >=0) and read macroblock rm (if >=0) side by side
  task automatic pass(input int wm, input int rm);
    for (int a = 0; a < NW; a++) begin
      wr_en   = (wm >= 0);
      wr_addr = AW'(a);
      wr_data = (wm >= 0) ? word_of(wm, a) : '0;
      rd_en   = (rm >= 0);
      rd_addr = AW'(a);
      if (rm >= 0) exp_q.push_back(word_of(rm, a));
      step();
    end
    idle();
  endtask

  task automatic pulse_wr_done(input int m);
    wr_done = 1; wr_ctrl = ctrl_of(m);
    step();
    wr_done = 0;
  endtask

  initial begin
    #(2.0 * HALF * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; idle(); wr_addr = '0; rd_addr = '0; wr_data = '0; wr_ctrl = '0;
    step(); step();
    // R1 during reset
    check(cons_valid === 0 && prod_ready === 1 && swap === 0, "R1 in reset", {cons_valid, prod_ready, swap}, 3'b010);
    rst_n = 1;
    step();
    check(cons_valid === 0 && prod_ready === 1 && swap === 0, "R1 after release", {cons_valid, prod_ready, swap}, 3'b010);
    check(rd_ctrl === '0, "R1 ctrl", rd_ctrl, 0);

    // first macroblock, consumer idle
    pass(0, -1);
    check(swap === 0, "R2 no swap before done", swap, 0);
    pulse_wr_done(0);
    check(swap === 1 && cons_valid === 1 && prod_ready === 1, "R2 first exchange", {swap, cons_valid, prod_ready}, 3'b111);
    check(rd_ctrl === ctrl_of(0), "R7 ctrl after exchange", rd_ctrl, ctrl_of(0));
    step();
    check(swap === 0, "R2 swap single cycle", swap, 0);

    // read mb0 while writing mb1 into the other region
    pass(1, 0);
    step();
    check(exp_q.size() == 0, "R5 all reads returned", exp_q.size(), 0);

    // producer finishes while consumer still busy
    pulse_wr_done(1);
    check(prod_ready === 0 && swap === 0, "R3 producer blocked", {prod_ready, swap}, 2'b00);
    // dropped writes and a dropped second finish
    for (int a = 0; a < 4; a++) begin
      wr_en = 1; wr_addr = AW'(a); wr_data = '1;
      step();
    end
    idle();
    wr_done = 1; wr_ctrl = 16'hDEAD; step(); wr_done = 0;
    check(prod_ready === 0 && cons_valid === 1, "R3 still blocked", {prod_ready, cons_valid}, 2'b01);
    check(rd_ctrl === ctrl_of(0), "R7 ctrl stable while blocked", rd_ctrl, ctrl_of(0));

    // consumer releases -> exchange
    rd_done = 1; step(); rd_done = 0;
    check(swap === 1 && prod_ready === 1 && cons_valid === 1, "R2 exchange on rd_done", {swap, prod_ready, cons_valid}, 3'b111);
    check(rd_ctrl === ctrl_of(1), "R3/R7 ctrl of pending mb kept", rd_ctrl, ctrl_of(1));
    pass(-1, 1); // R3: mb1 intact despite dropped writes
    step();

    // R8 explicit lane and last-address check on mb1
    rd_en = 1; rd_addr = AW'(NW - 1); exp_q.push_back(word_of(1, NW - 1)); step(); rd_en = 0;
    step();
    check(rd_data[3*SW +: SW] === word_of(1, NW - 1)[3*SW +: SW], "R8 lane 3 of last word", rd_data[3*SW +: SW], word_of(1, NW - 1)[3*SW +: SW]);
    check(rd_data[0 +: SW] === 8'((97 + (NW - 1) * 4) & 255), "R8 lane 0 is row 0", rd_data[0 +: SW], 8'((97 + (NW - 1) * 4) & 255));

    // R6 release with nothing pending
    rd_done = 1; step(); rd_done = 0;
    check(cons_valid === 0 && swap === 0, "R6 release clears valid", {cons_valid, swap}, 2'b00);

    // mb2 then mb3 with simultaneous finishes
    pass(2, -1);
    pulse_wr_done(2);
    check(swap === 1 && rd_ctrl === ctrl_of(2), "R2 exchange mb2", {swap, rd_ctrl}, {1'b1, ctrl_of(2)});
    pass(3, 2);
    step();
    wr_done = 1; wr_ctrl = ctrl_of(3); rd_done = 1; step(); idle();
    check(swap === 1 && cons_valid === 1 && prod_ready === 1, "R9 joint finish exchanges", {swap, cons_valid, prod_ready}, 3'b111);
    check(rd_ctrl === ctrl_of(3), "R9/R7 ctrl mb3", rd_ctrl, ctrl_of(3));
    pass(-1, 3);
    step(); step();
    check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule